// File: doc/BRIEF.md
# Power-Save and Lock-Report Controller

This block decides which parts of a dual-loop frequency synthesizer are powered. There are three parts: the first loop, the second loop and the reference buffer. Two external save pins act at once and take priority. When both pins are high, three configuration bits decide. These bits are captured only when the serial strobe rises.

The same strobe edge also captures a 2-bit selection for the lock-report output. That selection picks what the output reports:

- nothing (the output is held low),
- the second loop,
- the first loop,
- both loops together.

The output uses open-drain semantics. The block drives a pull-low request when the selected loop is unlocked. It releases the line when the loop is locked or powered down. A powered-down loop counts as locked when both loops are reported.

Top module: `pwrlock_top`

## Requirements
- R1: With both save pins low, all three enables (first loop, second loop, reference buffer) are 0, whatever the captured bits are.
- R2: With only the second-loop pin high, the second loop and the buffer are enabled and the first loop is disabled.
- R3: With only the first-loop pin high, the first loop and the buffer are enabled and the second loop is disabled.
- R4: With both pins high, captured bits {first, second, ref} = 000 disable everything, and 001 enable the buffer only.
- R5: With both pins high, the first-loop bit alone enables the first loop plus the buffer, and the second-loop bit alone enables the second loop plus the buffer. Both bits enable all three. The ref bit has no effect while either loop bit is set.
- R6: The save bits and the lock selection are captured only on the clock edge where the strobe is high after having been low. Data changes without a new rising strobe, including a strobe held high, have no effect.
- R7: Save-pin changes reach the enables in the same cycle, with no register in the path.
- R8: After reset the captured bits are 000 and the selection is 00, so all enables are 0 and the pull-low request is 1.
- R9: Selection code 00 holds the pull-low request at 1. Code 01 requests pull-low exactly when the second loop is enabled and unlocked. Code 10 does the same for the first loop.
- R10: Selection code 11 requests pull-low when any enabled loop is unlocked. A disabled loop counts as locked.
- R11: When the reported loop is disabled, the request is 0 (released) even if its lock flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bsPinPll1 | input | 1 | First-loop save pin, high = allow |
| bsPinPll2 | input | 1 | Second-loop save pin, high = allow |
| cfgSavePll1 | input | 1 | Serial bit enabling the first loop |
| cfgSavePll2 | input | 1 | Serial bit enabling the second loop |
| cfgSaveRef | input | 1 | Serial bit enabling the buffer alone |
| cfgLockSel | input | 2 | Lock-report selection (00 off, 01 second, 10 first, 11 both) |
| cfgStrobe | input | 1 | Serial strobe, captured on its rising edge |
| lockPll1 | input | 1 | First-loop lock flag |
| lockPll2 | input | 1 | Second-loop lock flag |
| enPll1 | output | 1 | First-loop enable |
| enPll2 | output | 1 | Second-loop enable |
| enRefBuf | output | 1 | Reference buffer enable |
| lockPullLow | output | 1 | Request to pull the lock line low |

## Verification
The embedded properties check the following on every cycle:

- the pin-priority cases,
- the stability of the captured bits between strobe edges,
- the single-cycle load pulse,
- the forced-low selection,
- the release of the line for a disabled reported loop.

Only the bench scenarios can show the rest:

- that the ref bit is ignored beside a loop bit,
- that a held strobe loads once,
- that pin changes act within the same cycle,
- every selection code against varied lock flags.

// File: rtl/pwrlock_pkg.sv
package pwrlock_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    LK_OFF  = 2'b00,
    LK_P2   = 2'b01,
    LK_P1   = 2'b10,
    LK_BOTH = 2'b11
  } lockSel_e;

  typedef struct packed {
    logic loadSave;
    logic loadSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/pwrlock_ctrl.sv
module pwrlock_ctrl
  import pwrlock_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         strobeIn,
  output ctrlStrobes_t strobes
);
  logic strobePrev;

  // Reset to 1 so that a strobe already high at reset release does not load.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobePrev <= 1'b1;
    else       strobePrev <= strobeIn;
  end

  logic riseSeen;
  assign riseSeen = strobeIn && !strobePrev;

  always_comb begin
    strobes.loadSave = riseSeen;
    strobes.loadSel  = riseSeen;
  end

  // R6: a load strobe never lasts two cycles
  a_r6_single_load: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadSave |=> !strobes.loadSave);
endmodule

// File: rtl/pwrlock_dp.sv
module pwrlock_dp
  import pwrlock_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  logic         pin1,
  input  logic         pin2,
  input  logic         sb1,
  input  logic         sb2,
  input  logic         sbRef,
  input  logic [SEL_W-1:0] selIn,
  input  logic         lock1,
  input  logic         lock2,
  output logic         en1,
  output logic         en2,
  output logic         enRef,
  output logic         pullLow
);
  logic [2:0] saveQ;      // {loop1, loop2, ref}
  lockSel_e   selQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      saveQ <= 3'b000;
      selQ  <= LK_OFF;
    end else begin
      if (strobes.loadSave) saveQ <= {sb1, sb2, sbRef};
      if (strobes.loadSel)  selQ  <= lockSel_e'(selIn);
    end
  end

  always_comb begin
    unique case ({pin1, pin2})
      2'b00: {en1, en2, enRef} = 3'b000;
      2'b01: {en1, en2, enRef} = 3'b011;
      2'b10: {en1, en2, enRef} = 3'b101;
      default: begin
        en1   = saveQ[2];
        en2   = saveQ[1];
        enRef = saveQ[2] | saveQ[1] | saveQ[0];
      end
    endcase
  end

  logic bad1, bad2;
  assign bad1 = en1 && !lock1;
  assign bad2 = en2 && !lock2;

  always_comb begin
    unique case (selQ)
      LK_OFF:  pullLow = 1'b1;
      LK_P2:   pullLow = bad2;
      LK_P1:   pullLow = bad1;
      default: pullLow = bad1 | bad2;
    endcase
  end

  // R1: both pins low forces everything off
  a_r1_pins_low_off: assert property (@(posedge clk) disable iff (!rstN)
    (!pin1 && !pin2) |-> !(en1 || en2 || enRef));
  // R2: second-loop pin alone
  a_r2_pin2_only: assert property (@(posedge clk) disable iff (!rstN)
    (!pin1 && pin2) |-> (en2 && enRef && !en1));
  // R3: first-loop pin alone
  a_r3_pin1_only: assert property (@(posedge clk) disable iff (!rstN)
    (pin1 && !pin2) |-> (en1 && enRef && !en2));
  // R6: captured bits hold without a load strobe
  a_r6_hold_bits: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadSave |=> $stable(saveQ));
  // R9: code 00 keeps the line low
  a_r9_sel_off_low: assert property (@(posedge clk) disable iff (!rstN)
    (selQ == LK_OFF) |-> pullLow);
  // R11: disabled reported loop releases the line
  a_r11_down_released: assert property (@(posedge clk) disable iff (!rstN)
    (((selQ == LK_P2) && !en2) || ((selQ == LK_P1) && !en1)) |-> !pullLow);
endmodule

// File: rtl/pwrlock_top.sv
module pwrlock_top
  import pwrlock_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bsPinPll1,
  input  logic       bsPinPll2,
  input  logic       cfgSavePll1,
  input  logic       cfgSavePll2,
  input  logic       cfgSaveRef,
  input  logic [1:0] cfgLockSel,
  input  logic       cfgStrobe,
  input  logic       lockPll1,
  input  logic       lockPll2,
  output logic       enPll1,
  output logic       enPll2,
  output logic       enRefBuf,
  output logic       lockPullLow
);
  ctrlStrobes_t strobes;

  pwrlock_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .strobeIn(cfgStrobe), .strobes(strobes)
  );

  pwrlock_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .pin1(bsPinPll1), .pin2(bsPinPll2),
    .sb1(cfgSavePll1), .sb2(cfgSavePll2), .sbRef(cfgSaveRef),
    .selIn(cfgLockSel), .lock1(lockPll1), .lock2(lockPll2),
    .en1(enPll1), .en2(enPll2), .enRef(enRefBuf), .pullLow(lockPullLow)
  );
endmodule

// File: tb/pwrlock_top_bench.sv
module pwrlock_top_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic p1 = 0, p2 = 0, s1 = 0, s2 = 0, sr = 0, stb = 0, lk1 = 0, lk2 = 0;
  logic [1:0] sel = 2'b00;
  logic e1, e2, er, pl;

  int checks = 0, fails = 0;

  // Bench-side view of the captured configuration
  logic [2:0] shSave = 3'b000;
  logic [1:0] shSel  = 2'b00;

  typedef struct { logic [3:0] exp; string tag; } item_t;
  item_t q[$];
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  pwrlock_top u_pwrlock_top (
    .clk(clk), .rstN(rstN), .bsPinPll1(p1), .bsPinPll2(p2),
    .cfgSavePll1(s1), .cfgSavePll2(s2), .cfgSaveRef(sr),
    .cfgLockSel(sel), .cfgStrobe(stb), .lockPll1(lk1), .lockPll2(lk2),
    .enPll1(e1), .enPll2(e2), .enRefBuf(er), .lockPullLow(pl)
  );

  function automatic logic [3:0] model();
    logic a, b, c, d;
    case ({p1, p2})
      2'b00: {a, b, c} = 3'b000;
      2'b01: {a, b, c} = 3'b011;
      2'b10: {a, b, c} = 3'b101;
      default: begin a = shSave[2]; b = shSave[1]; c = |shSave; end
    endcase
    case (shSel)
      2'b00: d = 1'b1;
      2'b01: d = b && !lk2;
      2'b10: d = a && !lk1;
      default: d = (a && !lk1) || (b && !lk2);
    endcase
    return {a, b, c, d};
  endfunction

  task automatic expectNow(input logic [3:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    q.push_back(it);
    #3;
  endtask

  task automatic expectModel(input string tag);
    expectNow(model(), tag);
  endtask

  task automatic setPins(input logic a, input logic b);
    @(negedge clk); p1 = a; p2 = b;
  endtask

  task automatic setLocks(input logic a, input logic b);
    @(negedge clk); lk1 = a; lk2 = b;
  endtask

  task automatic loadCfg(input logic a, input logic b, input logic c, input logic [1:0] s);
    @(negedge clk); s1 = a; s2 = b; sr = c; sel = s; stb = 1;
    @(negedge clk); stb = 0;
    shSave = {a, b, c}; shSel = s;
  endtask

  // Monitor: pops expected items and compares them with the outputs
  initial begin
    forever begin
      wait (q.size() > 0);
      #2;
      begin
        item_t it;
        it = q.pop_front();
        checks++;
        if ({e1, e2, er, pl} !== it.exp) begin
          fails++;
          $display("FAIL %s: got %b expected %b", it.tag, {e1, e2, er, pl}, it.exp);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R8: reset state seen with both pins high
    setPins(1, 1);
    expectNow(4'b0001, "R8 reset state");
    setPins(0, 0);
    expectNow(4'b0001, "R1 pins low after reset");

    setPins(1, 1);
    loadCfg(0, 0, 1, 2'b00);
    expectNow(4'b0011, "R4 ref only, R9 sel 00 low");
    loadCfg(0, 0, 0, 2'b00);
    expectNow(4'b0001, "R4 all off");
    loadCfg(0, 1, 0, 2'b00);
    expectNow(4'b0111, "R5 second loop");
    loadCfg(0, 1, 1, 2'b00);
    expectNow(4'b0111, "R5 second loop ref ignored");
    loadCfg(1, 0, 1, 2'b00);
    expectNow(4'b1011, "R5 first loop ref ignored");
    loadCfg(1, 1, 0, 2'b00);
    expectNow(4'b1111, "R5 all on");

    // R7: pins act in the same cycle; R1/R2/R3
    @(negedge clk); p1 = 0; p2 = 0;
    expectNow(4'b0001, "R1 R7 pins low");
    @(negedge clk); p1 = 0; p2 = 1;
    expectNow(4'b0111, "R2 R7 second pin only");
    @(negedge clk); p1 = 1; p2 = 0;
    expectNow(4'b1011, "R3 R7 first pin only");
    setPins(1, 1);

    // R6: data changes without strobe edge ignored
    @(negedge clk); s1 = 0; s2 = 0; sr = 0; sel = 2'b11;
    repeat (2) @(negedge clk);
    expectNow(4'b1111, "R6 no strobe no change");
    // R6: held strobe loads once
    @(negedge clk); s1 = 0; s2 = 0; sr = 1; sel = 2'b00; stb = 1;
    @(negedge clk); s1 = 0; s2 = 0; sr = 0;
    @(negedge clk);
    shSave = 3'b001; shSel = 2'b00;
    expectNow(4'b0011, "R6 held strobe single load");
    stb = 0;

    // Lock reporting
    loadCfg(1, 1, 0, 2'b01);
    setLocks(1, 0);
    expectModel("R9 sel 01 unlocked");
    expectNow(4'b1111, "R9 sel 01 unlocked explicit");
    setLocks(0, 1);
    expectNow(4'b1110, "R9 sel 01 locked");
    loadCfg(1, 1, 0, 2'b10);
    expectNow(4'b1111, "R9 sel 10 unlocked");
    setLocks(1, 0);
    expectNow(4'b1110, "R9 sel 10 locked");
    loadCfg(1, 1, 0, 2'b11);
    expectNow(4'b1111, "R10 both one unlocked");
    setLocks(1, 1);
    expectNow(4'b1110, "R10 both locked");
    setLocks(0, 1);
    setPins(0, 1);
    expectNow(4'b0110, "R10 disabled loop counts locked");
    setPins(1, 1);
    expectModel("R10 enabled unlocked");
    loadCfg(0, 0, 1, 2'b01);
    setLocks(0, 0);
    expectNow(4'b0010, "R11 reported loop down released");
    setPins(0, 0);
    loadCfg(1, 1, 0, 2'b10);
    expectNow(4'b0000, "R11 R1 first loop down released");

    done = 1;
    #10;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule